// File: doc/BRIEF.md
# Parity-Protected Bidirectional Byte Lane

This block is one lane of a bus bridge that carries a byte between two buses, called side A and side B. Traffic toward side B gains a ninth bit, a parity bit, chosen so that the byte plus that bit hold an odd number of ones. Traffic toward side A is checked. The side-B byte and its incoming parity bit are tested for odd parity, and the outcome is stored in a clocked, active-low error flag. Every bidirectional pin is modelled as three ports: an input value, an output value and a drive enable.

Two active-low output enables choose the behaviour:

- Enabling only the B-side outputs sends A to B with correct parity.
- Enabling only the A-side outputs sends B to A and arms the checker.
- Holding both enables inactive drives neither bus, so the buses are isolated.
- Enabling both is a diagnostic mode. Data still goes from A to B, but the parity bit is deliberately wrong, so a downstream checker can be tested.

The error flag behaves like an open-collector line. It only pulls low, and it floats high otherwise. An asynchronous active-low clear forces the flag back to its idle high level.

Top module: `parity_xcvr_lane`

## Requirements
- R1: While `clrN` is low, `errN` is 1 and `errDrv` is 0. This takes effect without waiting for a clock edge, and it holds across rising edges of `clk` even when a bad-parity word is present in the B-to-A direction.
- R2: With `oeBN`=0 and `oeAN`=1, `bOut` equals `aIn`, `bDrv`=1, `parDrv`=1, `aDrv`=0, and `parOut` makes the count of ones in {`bOut`,`parOut`} odd.
- R3: With `oeAN`=0 and `oeBN`=0, `bOut` equals `aIn`, `bDrv`=1, `parDrv`=1, `aDrv`=0, and `parOut` makes the count of ones in {`bOut`,`parOut`} even (inverted parity).
- R4: With `oeAN`=0 and `oeBN`=1, `aOut` equals `bIn`, `aDrv`=1, `bDrv`=0 and `parDrv`=0.
- R5: In the R4 configuration, each rising edge of `clk` loads `errN` with 1 if {`bIn`,`parIn`} has an odd count of ones, and with 0 otherwise. The result is visible right after that edge.
- R6: On a rising edge of `clk` in any configuration other than R4, with `clrN` high, `errN` becomes 1. This clears any error flagged earlier.
- R7: With `oeAN`=1 and `oeBN`=1, `aDrv`, `bDrv` and `parDrv` are all 0.
- R8: `errDrv` is 1 exactly when `errN` is 0. The error line is pulled low only and never driven high.
- R9: `aDrv` and `bDrv` are never 1 at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock that loads the error flag on its rising edge |
| clrN | input | 1 | Asynchronous active-low clear of the error flag |
| oeAN | input | 1 | Active-low enable of the A-side outputs |
| oeBN | input | 1 | Active-low enable of the B-side and parity outputs |
| aIn | input | 8 | Value seen on the A-side bus |
| aOut | output | 8 | Value driven onto the A-side bus |
| aDrv | output | 1 | Drive enable of the A-side bus |
| bIn | input | 8 | Value seen on the B-side bus |
| bOut | output | 8 | Value driven onto the B-side bus |
| bDrv | output | 1 | Drive enable of the B-side bus |
| parIn | input | 1 | Value seen on the parity pin |
| parOut | output | 1 | Parity value driven onto the parity pin |
| parDrv | output | 1 | Drive enable of the parity pin |
| errN | output | 1 | Resolved level of the error line, low when an error is flagged |
| errDrv | output | 1 | Pull-down enable of the open-collector error line |

## Verification
Two kinds of result have different latencies, and the checks follow each one.

**Combinational outputs.** The bus values, the parity bit and the drive enables depend only on the current inputs. The bench changes inputs on the falling edge and samples one time unit later, with no clock edge in between.

**Error flag.** The flag is due at the first rising edge after its inputs settle. The bench samples it one time unit after that edge and before the next falling edge. An idle mode is applied for exactly one edge to show that a stored error is released at that edge.

**Clear.** The clear is checked in the middle of a cycle, one time unit after it falls and with no clock edge in between. It is then held across an edge that would otherwise load an error.

// File: rtl/ptx_pkg.sv
package ptx_pkg;

  // Lane operating mode decoded from the two enables.
  typedef enum logic [1:0] {
    MODE_ISOLATE = 2'd0,
    MODE_A2B     = 2'd1,
    MODE_B2A     = 2'd2,
    MODE_DIAG    = 2'd3
  } laneMode_e;

  // Strobes passed from control to datapath.
  typedef struct packed {
    logic driveA;   // A-side bus driven from B
    logic driveB;   // B-side bus and parity pin driven from A
    logic invPar;   // emit wrong parity on purpose
    logic chkEn;    // checker result may load the error flag
  } laneStrobe_t;

  // Bit that completes an odd count of ones over a word.
  function automatic logic oddFill(input logic [15:0] word, input int unsigned width);
    logic acc;
    acc = 1'b1;
    for (int i = 0; i < 16; i++) begin
      if (i < width) acc = acc ^ word[i];
    end
    return acc;
  endfunction

endpackage

// File: rtl/ptx_ctrl.sv
module ptx_ctrl
  import ptx_pkg::*;
(
  input  logic        oeAN,
  input  logic        oeBN,
  output laneStrobe_t stb
);

  laneMode_e mode;

  always_comb begin
    case ({oeAN, oeBN})
      2'b10:   mode = MODE_A2B;
      2'b01:   mode = MODE_B2A;
      2'b00:   mode = MODE_DIAG;
      default: mode = MODE_ISOLATE;
    endcase
  end

  always_comb begin
    stb = '0;
    case (mode)
      MODE_A2B:  stb.driveB = 1'b1;
      MODE_DIAG: begin
        stb.driveB = 1'b1;
        stb.invPar = 1'b1;
      end
      MODE_B2A: begin
        stb.driveA = 1'b1;
        stb.chkEn  = 1'b1;
      end
      default: stb = '0;
    endcase
  end

  // R9: never drive both buses at once
  always_comb begin
    a_r9_one_side: assert (!(stb.driveA && stb.driveB));
  end

endmodule

// File: rtl/ptx_datapath.sv
module ptx_datapath
  import ptx_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              clrN,
  input  laneStrobe_t       stb,
  input  logic [DATA_W-1:0] aIn,
  input  logic [DATA_W-1:0] bIn,
  input  logic              parIn,
  output logic [DATA_W-1:0] aOut,
  output logic [DATA_W-1:0] bOut,
  output logic              parOut,
  output logic              errQ
);

  localparam int unsigned PAD_W = 16 - DATA_W;

  logic genPar;
  logic chkOdd;
  logic loadVal;

  // Parity generator for the A-to-B path.
  assign genPar = oddFill({{PAD_W{1'b0}}, aIn}, DATA_W);

  // Checker for the B-to-A path: odd over data plus parity pin.
  assign chkOdd = ^{bIn, parIn};

  assign aOut   = stb.driveA ? bIn : '0;
  assign bOut   = stb.driveB ? aIn : '0;
  assign parOut = stb.driveB ? (genPar ^ stb.invPar) : 1'b0;

  // Active-high internal error; idle modes load "no error".
  assign loadVal = stb.chkEn & ~chkOdd;

  always_ff @(posedge clk or negedge clrN) begin
    if (!clrN) errQ <= 1'b0;
    else       errQ <= loadVal;
  end

  // R2: normal A-to-B output carries odd parity
  a_r2_odd_out: assert property (@(posedge clk) disable iff (!clrN)
    (stb.driveB && !stb.invPar) |-> (^{bOut, parOut}));

  // R3: diagnostic output carries even parity
  a_r3_even_out: assert property (@(posedge clk) disable iff (!clrN)
    (stb.driveB && stb.invPar) |-> !(^{bOut, parOut}));

  // R1: a held clear keeps the flag idle across edges
  a_r1_clear_hold: assert property (@(posedge clk)
    (!clrN && $past(!clrN)) |-> !errQ);

endmodule

// File: rtl/parity_xcvr_lane.sv
module parity_xcvr_lane
  import ptx_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              clrN,
  input  logic              oeAN,
  input  logic              oeBN,
  input  logic [DATA_W-1:0] aIn,
  output logic [DATA_W-1:0] aOut,
  output logic              aDrv,
  input  logic [DATA_W-1:0] bIn,
  output logic [DATA_W-1:0] bOut,
  output logic              bDrv,
  input  logic              parIn,
  output logic              parOut,
  output logic              parDrv,
  output logic              errN,
  output logic              errDrv
);

  laneStrobe_t stb;
  logic        errQ;

  ptx_ctrl u_ctrl (
    .oeAN (oeAN),
    .oeBN (oeBN),
    .stb  (stb)
  );

  ptx_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk    (clk),
    .clrN   (clrN),
    .stb    (stb),
    .aIn    (aIn),
    .bIn    (bIn),
    .parIn  (parIn),
    .aOut   (aOut),
    .bOut   (bOut),
    .parOut (parOut),
    .errQ   (errQ)
  );

  assign aDrv   = stb.driveA;
  assign bDrv   = stb.driveB;
  assign parDrv = stb.driveB;

  // Open-collector error line: pull low only, float high otherwise.
  assign errDrv = errQ;
  assign errN   = ~errQ;

  // R5: checked result appears after the edge
  a_r5_capture: assert property (@(posedge clk) disable iff (!clrN)
    (!oeAN && oeBN) |=> (errN == $past(^{bIn, parIn})));

  // R6: idle modes release the flag at the edge
  a_r6_release: assert property (@(posedge clk) disable iff (!clrN)
    !(!oeAN && oeBN) |=> errN);

  // R7: isolation drives nothing
  a_r7_isolate: assert property (@(posedge clk) disable iff (!clrN)
    (oeAN && oeBN) |-> (!aDrv && !bDrv && !parDrv));

endmodule

// File: tb/sim_parity_xcvr_lane.sv
module sim_parity_xcvr_lane;

  localparam int CLK_PER = 10;

  logic       clk = 1'b0;
  logic       clrN;
  logic       oeAN, oeBN;
  logic [7:0] aIn, bIn;
  logic       parIn;
  logic [7:0] aOut, bOut;
  logic       aDrv, bDrv, parDrv, parOut, errN, errDrv;

  int total = 0;
  int bad   = 0;

  always #(CLK_PER/2) clk = ~clk;

  parity_xcvr_lane u0 (
    .clk(clk), .clrN(clrN), .oeAN(oeAN), .oeBN(oeBN),
    .aIn(aIn), .aOut(aOut), .aDrv(aDrv),
    .bIn(bIn), .bOut(bOut), .bDrv(bDrv),
    .parIn(parIn), .parOut(parOut), .parDrv(parDrv),
    .errN(errN), .errDrv(errDrv)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Flag and its pull-down must agree (R8).
  task automatic chkErr(input bit expN, input string req);
    chk(errN == expN, req, errN, expN);
    chk(errDrv == !expN, "R8", errDrv, !expN);
  endtask

  task automatic finishRun;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    finishRun();
  end

  initial begin
    clrN = 1'b1; oeAN = 1'b1; oeBN = 1'b1;
    aIn = '0; bIn = '0; parIn = 1'b0;
    #2 clrN = 1'b0;
    repeat (2) @(negedge clk);
    #1;
    chkErr(1'b1, "R1");
    chk({aDrv, bDrv, parDrv} == 3'b000, "R7", {aDrv, bDrv, parDrv}, 0);
    clrN = 1'b1;

    // R7: isolation sweep
    for (int v = 0; v < 256; v++) begin
      @(negedge clk);
      aIn = v[7:0];
      bIn = ~v[7:0];
      parIn = v[0];
      #1;
      chk({aDrv, bDrv, parDrv} == 3'b000, "R7", {aDrv, bDrv, parDrv}, 0);
    end

    // R2: normal A-to-B, odd parity
    oeAN = 1'b1; oeBN = 1'b0;
    for (int v = 0; v < 256; v++) begin
      @(negedge clk);
      aIn = v[7:0];
      bIn = ~v[7:0];
      #1;
      chk(bOut == v[7:0], "R2", bOut, v);
      chk({aDrv, bDrv, parDrv} == 3'b011, "R2", {aDrv, bDrv, parDrv}, 3);
      chk(parOut == ~(^v[7:0]), "R2", parOut, ~(^v[7:0]));
      chk(!(aDrv && bDrv), "R9", aDrv, 0);
    end

    // R3: diagnostic mode, inverted parity
    oeAN = 1'b0; oeBN = 1'b0;
    for (int v = 0; v < 256; v++) begin
      @(negedge clk);
      aIn = v[7:0];
      bIn = ~v[7:0];
      #1;
      chk(bOut == v[7:0], "R3", bOut, v);
      chk({aDrv, bDrv, parDrv} == 3'b011, "R3", {aDrv, bDrv, parDrv}, 3);
      chk(parOut == (^v[7:0]), "R3", parOut, ^v[7:0]);
    end

    // R4 and R5: B-to-A over every data and parity combination
    oeAN = 1'b0; oeBN = 1'b1;
    for (int v = 0; v < 512; v++) begin
      @(negedge clk);
      bIn = v[8:1];
      parIn = v[0];
      aIn = ~v[7:0];
      #1;
      chk(aOut == v[8:1], "R4", aOut, v[8:1]);
      chk({aDrv, bDrv, parDrv} == 3'b100, "R4", {aDrv, bDrv, parDrv}, 4);
      chk(!(aDrv && bDrv), "R9", bDrv, 0);
      @(posedge clk);
      #1;
      chkErr(^v[8:0], "R5");
    end

    // R6: each non-checking mode releases a stored error at one edge
    for (int m = 0; m < 3; m++) begin
      @(negedge clk);
      oeAN = 1'b0; oeBN = 1'b1; bIn = 8'h00; parIn = 1'b0;
      @(posedge clk);
      #1;
      chkErr(1'b0, "R5");
      @(negedge clk);
      case (m)
        0: begin oeAN = 1'b1; oeBN = 1'b1; end
        1: begin oeAN = 1'b1; oeBN = 1'b0; end
        default: begin oeAN = 1'b0; oeBN = 1'b0; end
      endcase
      #1;
      chkErr(1'b0, "R6");
      @(posedge clk);
      #1;
      chkErr(1'b1, "R6");
    end

    // R1: asynchronous clear, held over a bad-parity edge
    @(negedge clk);
    oeAN = 1'b0; oeBN = 1'b1; bIn = 8'h03; parIn = 1'b0;
    @(posedge clk);
    #1;
    chkErr(1'b0, "R5");
    #1 clrN = 1'b0;
    #1;
    chkErr(1'b1, "R1");
    @(posedge clk);
    #1;
    chkErr(1'b1, "R1");
    @(negedge clk);
    clrN = 1'b1;
    @(posedge clk);
    #1;
    chkErr(1'b0, "R5");

    @(negedge clk);
    finishRun();
  end

endmodule